// File: doc/BRIEF.md
# Prescaled Programmable Baud Generator

This block turns a reference clock into the periodic oversampling enable that a UART transmitter and receiver use. A 16-bit divisor sets the period. A select bit can add a fixed divide-by-four stage, so the enable rate is either ref/N or ref/(4N). The divide-by-four stage sits in front of the programmable divider.

The output `tick` is a single-cycle enable and not a clock. Downstream logic qualifies its registers with it. A divisor of zero stops the enable completely.

Software may rewrite the divisor at any time. A new value is taken only when the current period ends, so no period is ever cut short.

Top module: `baud_tick_gen`

## Requirements
- R1: With `quad_sel` at 0 and a divisor N of 1 or more, consecutive `tick` pulses are exactly N reference cycles apart.
- R2: With `quad_sel` at 1 the divide-by-four stage runs ahead of the divider, so consecutive pulses are exactly 4N reference cycles apart.
- R3: While the divisor in use is 0, `tick` stays low for any length of time. A nonzero value written later starts pulses within one period plus a few cycles.
- R4: With divisor 1 and `quad_sel` at 0, `tick` is high on every reference cycle.
- R5: When the period is longer than one cycle, `tick` is high for exactly one reference cycle per period.
- R6: During reset `tick` is low and both counters are cleared.
  - After reset is released, the first pulse appears N+1 cycles later with `quad_sel` at 0.
  - With `quad_sel` at 1, it appears 4N+4 cycles later.
- R7: A divisor change made during a period does not alter that period. The new value governs the period that starts at the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Divide ratio N, 0 to 65535; 0 stops the output |
| quad_sel | input | 1 | 1 enables the divide-by-four prescaler |
| tick | output | 1 | One-cycle enable at ref/N or ref/(4N) |

## Verification
A table of divisor and prescaler pairs is swept, including divisor 1 and values from 2 to a few thousand. Each pair is measured for its first-pulse latency and several consecutive pulse spacings. Running the same divisors with and without the prescaler separates a missing or misplaced divide-by-four from a divider error. Divisor 1 distinguishes a constant-high output from an off-by-one reload. A divisor change in the middle of a period separates deferred loading from immediate loading. Holding the divisor at zero and then writing a nonzero value checks that the idle state is clean and can restart.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 16,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             quad_sel,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur;
  logic             step;
  logic             terminal;

  assign step     = quad_sel ? (pcnt == PRE_LAST) : 1'b1;
  assign terminal = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      cnt  <= '0;
      cur  <= '0;
      tick <= 1'b0;
    end else begin
      pcnt <= quad_sel ? pcnt + 1'b1 : '0;
      tick <= terminal && (cur != '0);
      if (terminal) begin
        cur <= divisor;
        cnt <= (divisor == '0) ? '0 : divisor - 1'b1;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             quad_sel,
  input logic             tick,
  input logic             step,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] cur
);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && divisor == '0) |=> !tick);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !quad_sel && cur > 1) |=> !tick);

  p_quad_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && quad_sel && $past(quad_sel)) |=> !tick);

  p_reset_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tick);

  p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0) |=> (cur == $past(cur)));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .quad_sel(quad_sel),
  .tick(tick), .step(step), .cnt(cnt), .cur(cur)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic        quad_sel = 1'b0;
  logic        tick;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .divisor(divisor),
    .quad_sel(quad_sel), .tick(tick)
  );

  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'd1}, {1'b0, 16'd2}, {1'b0, 16'd7}, {1'b0, 16'd1000},
    {1'b1, 16'd1}, {1'b1, 16'd3}, {1'b1, 16'd16}, {1'b0, 16'd4095},
    {1'b1, 16'd250}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < limit);
    if (!tick) n = -1;
  endtask

  task automatic do_reset(input logic [15:0] d, input logic q);
    @(negedge clk);
    rst_n = 1'b0;
    divisor = d;
    quad_sel = q;
    repeat (3) @(negedge clk);
    check("R6 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    int per;
    repeat (2) @(negedge clk);
    check("R6 tick low at start", int'(tick), 0);

    for (int i = 0; i < NV; i++) begin
      per = VEC[i][16] ? 4 * int'(VEC[i][15:0]) : int'(VEC[i][15:0]);
      do_reset(VEC[i][15:0], VEC[i][16]);
      wait_tick(per + 10, n);
      check("R6 first tick latency", n, per + (VEC[i][16] ? 4 : 1));
      for (int k = 0; k < 3; k++) begin
        wait_tick(per + 10, n);
        check(VEC[i][16] ? "R2 prescaled period" :
              (per == 1 ? "R4 every cycle" : "R1 period"), n, per);
      end
    end

    do_reset(16'd9, 1'b0);
    wait_tick(20, n);
    @(negedge clk);
    check("R5 single cycle pulse", int'(tick), 0);

    do_reset(16'd5, 1'b0);
    wait_tick(20, n);
    repeat (2) @(negedge clk);
    divisor = 16'd9;
    wait_tick(30, n);
    check("R7 current period kept", n, 3);
    wait_tick(30, n);
    check("R7 new divisor used", n, 9);

    do_reset(16'd4, 1'b1);
    wait_tick(40, n);
    repeat (5) @(negedge clk);
    divisor = 16'd2;
    wait_tick(40, n);
    check("R7 prescaled current period kept", n, 11);
    wait_tick(40, n);
    check("R7 prescaled new divisor", n, 8);

    do_reset(16'd0, 1'b0);
    wait_tick(300, n);
    check("R3 no tick with zero divisor", n, -1);
    do_reset(16'd0, 1'b1);
    wait_tick(300, n);
    check("R3 no tick with zero divisor prescaled", n, -1);
    divisor = 16'd3;
    quad_sel = 1'b0;
    wait_tick(10, n);
    check("R3 restart after nonzero write", int'(n > 0), 1);
    wait_tick(10, n);
    check("R1 period after restart", n, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule